// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port that exchanges 8-bit frames with a peer over three wires: a serial clock it generates, a data output and a data input. A frame moves one byte in each direction at the same time, least significant bit first. The serial clock is the system clock divided by a fixed even ratio and rests high between frames. The data output changes on each falling clock edge. The data input is sampled on each rising edge.

Software uses the block through four byte-wide registers. These are a transmit holding register, a receive holding register, a status register and a control register. The status register has three flags: transmit-empty, receive-full and overrun. Writing the transmit register clears transmit-empty. Reading the receive register clears receive-full. Transmit-empty sets again when the byte moves into the shift engine. A frame that completes while receive-full is still set raises overrun. Overrun stops all further frames until software writes 0 to that flag.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, status reads transmit-empty (bit 0) = 1, receive-full (bit 1) = 0 and overrun (bit 2) = 0. Control reads 0. The serial clock output is 1 and the data output is 1.
- R2: A write to address 0 (transmit register) clears transmit-empty at the next clock edge. Transmit-empty returns to 1 at the edge where the frame that takes this byte starts.
- R3: A frame has 8 serial clock periods of CLK_DIV system cycles each. The serial clock falls when the frame starts and rests high once the frame is over. The data output carries the transmit byte LSB first, changes only on falling serial clock edges, and is 1 when no byte is being sent.
- R4: The data input is sampled on each rising serial clock edge, and the first bit sampled is the LSB. On the 8th rising edge of a frame with receive enabled, the byte is placed at address 1 and receive-full sets.
- R5: A read of address 1 clears receive-full at the next clock edge.
- R6: If a frame completes while receive-full is 1, overrun sets. Address 1 keeps the earlier byte, and the new byte is discarded.
- R7: While overrun is 1, no frame starts and the serial clock stays high, even when a transmit byte is pending. Writing 0 to overrun lets the pending frame start.
- R8: A write to address 2 clears each flag whose data bit is 0. A 1 in a data bit leaves that flag unchanged.
- R9: Control is at address 3: bit 0 enables transmit and bit 1 enables receive. With transmit enabled, a frame starts only when a byte is pending. With only receive enabled, a frame starts whenever receive-full is 0, and the data output stays 1.
- R10: If both enable bits are cleared during a frame, the frame stops at the next edge and the serial clock returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of address 1 has a side effect) |
| addr | input | 2 | Register address: 0 transmit, 1 receive, 2 status, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |
| sck_o | output | 1 | Serial clock, high while idle |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
A register access takes effect at the clock edge that ends its strobe cycle. The bench drives strobes between edges and reads status one cycle later, after that edge. Frame results arrive on the serial clock. The bench drives each input bit right after a falling serial edge and reads each output bit just after a rising serial edge. The received byte and receive-full are due at the 8th rising serial edge, which is 15·CLK_DIV/2 cycles after the frame starts. The bench reads them only after the trailing high half-period. The abort and overrun-lock checks count serial clock edges over fixed windows of system cycles.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        REG_TXD  = 2'd0,
        REG_RXD  = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } ssp_addr_e;

    localparam int STAT_TXE  = 0;
    localparam int STAT_RXF  = 1;
    localparam int STAT_OVR  = 2;
    localparam int CTRL_TXEN = 0;
    localparam int CTRL_RXEN = 1;

    typedef struct packed {
        logic ovr;
        logic rx_full;
        logic tx_empty;
    } ssp_flags_t;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
    } ssp_ctrl_t;

    function automatic int ssp_cnt_w(input int half);
        return (half > 1) ? $clog2(half) : 1;
    endfunction
endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = ssp_pkg::ssp_cnt_w(HALF);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              ovr,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic [DATA_W-1:0] tdr,
    input  logic              sdi,
    output logic              busy,
    output logic              sck,
    output logic              sdo,
    output logic              load,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-2:0] rx_sh;
    logic [BIT_W-1:0]  bit_cnt;
    logic              start, abort, last;

    assign start   = !busy && !ovr &&
                     ((tx_en && !tx_empty) || (!tx_en && rx_en && !rx_full));
    assign abort   = busy && !tx_en && !rx_en;
    assign load    = start && tx_en;
    assign last    = (bit_cnt == LAST_BIT);
    assign rx_data = {sdi, rx_sh};
    assign rx_done = busy && !abort && tick && !sck && last;
    assign sdo     = tx_sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sck     <= 1'b1;
            tx_sh   <= '1;
            rx_sh   <= '0;
            bit_cnt <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            sck     <= 1'b0;
            tx_sh   <= tx_en ? tdr : '1;
            bit_cnt <= '0;
        end else if (abort) begin
            busy  <= 1'b0;
            sck   <= 1'b1;
            tx_sh <= '1;
        end else if (busy && tick) begin
            if (!sck) begin
                sck   <= 1'b1;
                rx_sh <= rx_data[DATA_W-1:1];
            end else if (last) begin
                busy  <= 1'b0;
                tx_sh <= '1;
            end else begin
                sck     <= 1'b0;
                tx_sh   <= {1'b1, tx_sh[DATA_W-1:1]};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // R3: clock rests high outside a frame
    assert_idle_high_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck);
    // R3: within a frame the clock only toggles on a divider tick
    assert_edge_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (sck != $past(sck))) |-> $past(tick));
    // R3: data out never moves on a rising clock edge
    assert_sdo_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> $stable(sdo));
    // R7: no frame begins while overrun is set
    assert_no_start_ovr_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(ovr));
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                load,
    input  logic                rx_done,
    input  logic [DATA_W-1:0]   rx_data,
    output logic [DATA_W-1:0]   tdr,
    output ssp_pkg::ssp_flags_t flags,
    output ssp_pkg::ssp_ctrl_t  ctrl
);
    import ssp_pkg::*;

    ssp_addr_e         sel;
    logic [DATA_W-1:0] rdr;
    ssp_flags_t        flags_n;
    logic              wr_txd, rd_rxd, wr_stat, wr_ctrl, rx_take, rx_lost;

    assign sel     = ssp_addr_e'(addr);
    assign wr_txd  = wr_en && (sel == REG_TXD);
    assign wr_stat = wr_en && (sel == REG_STAT);
    assign wr_ctrl = wr_en && (sel == REG_CTRL);
    assign rd_rxd  = rd_en && (sel == REG_RXD);
    assign rx_take = rx_done && ctrl.rx_en && !flags.rx_full;
    assign rx_lost = rx_done && ctrl.rx_en &&  flags.rx_full;

    always_comb begin
        flags_n = flags;
        if (load)                          flags_n.tx_empty = 1'b1;
        if (wr_txd)                        flags_n.tx_empty = 1'b0;
        if (rx_take)                       flags_n.rx_full  = 1'b1;
        if (rd_rxd)                        flags_n.rx_full  = 1'b0;
        if (rx_lost)                       flags_n.ovr      = 1'b1;
        if (wr_stat && !wdata[STAT_TXE])   flags_n.tx_empty = 1'b0;
        if (wr_stat && !wdata[STAT_RXF])   flags_n.rx_full  = 1'b0;
        if (wr_stat && !wdata[STAT_OVR])   flags_n.ovr      = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tdr   <= '0;
            rdr   <= '0;
            flags <= '{ovr: 1'b0, rx_full: 1'b0, tx_empty: 1'b1};
            ctrl  <= '0;
        end else begin
            flags <= flags_n;
            if (wr_txd)  tdr  <= wdata;
            if (rx_take) rdr  <= rx_data;
            if (wr_ctrl) ctrl <= '{rx_en: wdata[CTRL_RXEN], tx_en: wdata[CTRL_TXEN]};
        end
    end

    always_comb begin
        unique case (sel)
            REG_TXD:  rdata = tdr;
            REG_RXD:  rdata = rdr;
            REG_STAT: rdata = {{(DATA_W-3){1'b0}}, flags};
            default:  rdata = {{(DATA_W-2){1'b0}}, ctrl};
        endcase
    end

    // R2: writing the transmit register marks a byte pending
    assert_txd_write_R2: assert property (@(posedge clk) disable iff (rst)
        wr_txd |=> !flags.tx_empty);
    // R5: reading the receive register empties it
    assert_rxd_read_R5: assert property (@(posedge clk) disable iff (rst)
        rd_rxd |=> !flags.rx_full);
    // R6: a frame landing on a full register raises overrun
    assert_overrun_set_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_done && ctrl.rx_en && flags.rx_full && !wr_stat) |=> flags.ovr);
    // R6: the held byte survives while overrun is up
    assert_keep_rdr_R6: assert property (@(posedge clk) disable iff (rst)
        flags.ovr |=> $stable(rdr));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sck_o,
    output logic              sdo_o,
    input  logic              sdi_i
);
    import ssp_pkg::*;

    localparam int HALF = CLK_DIV / 2;

    ssp_flags_t        flags;
    ssp_ctrl_t         ctrl;
    logic [DATA_W-1:0] tdr, rx_data;
    logic              busy, tick, load, rx_done;

    initial begin
        if (CLK_DIV < 2 || (CLK_DIV % 2) != 0)
            $error("CLK_DIV must be even and at least 2");
    end

    ssp_baud #(.HALF(HALF)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    ssp_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .load    (load),
        .rx_done (rx_done),
        .rx_data (rx_data),
        .tdr     (tdr),
        .flags   (flags),
        .ctrl    (ctrl)
    );

    ssp_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .tx_en    (ctrl.tx_en),
        .rx_en    (ctrl.rx_en),
        .ovr      (flags.ovr),
        .tx_empty (flags.tx_empty),
        .rx_full  (flags.rx_full),
        .tdr      (tdr),
        .sdi      (sdi_i),
        .busy     (busy),
        .sck      (sck_o),
        .sdo      (sdo_o),
        .load     (load),
        .rx_done  (rx_done),
        .rx_data  (rx_data)
    );

    // R10: clearing both enables drops the clock high at the next edge
    assert_abort_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !ctrl.tx_en && !ctrl.rx_en) |=> (sck_o && !busy));
endmodule

// File: tb/sim_sync_serial_port.sv
`timescale 1ns/1ps
module sim_sync_serial_port;
    localparam int DIV = 4;
    localparam logic [15:0] VEC [4] = '{16'hA53C, 16'h0FF0, 16'h8001, 16'h5A6B};

    logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, sdi = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0, rdata;
    logic       sck, sdo;
    int         checks = 0, fails = 0, edges = 0;
    realtime    t_rise0, t_rise1;

    always #2.5 clk = ~clk;

    sync_serial_port #(.DATA_W(8), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sck_o(sck), .sdo_o(sdo), .sdi_i(sdi)
    );

    always @(sck) edges++;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #0.5 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] pat, output logic [7:0] cap);
        for (int i = 0; i < 8; i++) begin
            @(negedge sck); sdi = pat[i];
            @(posedge sck); #0.5 cap[i] = sdo;
            if (i == 0) t_rise0 = $realtime;
            if (i == 1) t_rise1 = $realtime;
        end
        repeat (DIV) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] rd, cap;
        int e0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        bus_rd(2'd2, rd); chk("R1 status", rd, 8'h01);
        bus_rd(2'd3, rd); chk("R1 control", rd, 8'h00);
        chk("R1 pins", {6'd0, sck, sdo}, 8'h03);
        // R8 writing ones has no effect, zero clears
        bus_wr(2'd2, 8'h07); bus_rd(2'd2, rd); chk("R8 ones no effect", rd, 8'h01);
        bus_wr(2'd2, 8'h06); bus_rd(2'd2, rd); chk("R8 zero clears", rd, 8'h00);

        // Vector table: full duplex frames (R2 R3 R4 R5)
        foreach (VEC[k]) begin
            bus_wr(2'd0, VEC[k][15:8]);
            bus_rd(2'd2, rd); chk("R2 tx pending", rd & 8'h01, 8'h00);
            fork
                bus_wr(2'd3, 8'h03);
                run_frame(VEC[k][7:0], cap);
            join
            chk("R3 sdo byte", cap, VEC[k][15:8]);
            bus_rd(2'd2, rd); chk("R4 rx_full and R2 tx_empty", rd, 8'h03);
            bus_wr(2'd3, 8'h00);
            bus_rd(2'd1, rd); chk("R4 rx byte", rd, VEC[k][7:0]);
            bus_rd(2'd2, rd); chk("R5 rx_full cleared", rd, 8'h01);
        end
        checks++;
        if (t_rise1 - t_rise0 != DIV * 5.0) begin
            fails++;
            $display("FAIL R3 period: actual %0t expected %0d", t_rise1 - t_rise0, DIV * 5);
        end

        // R6 / R7 overrun
        bus_wr(2'd0, 8'h11);
        fork bus_wr(2'd3, 8'h03); run_frame(8'h3C, cap); join
        fork bus_wr(2'd0, 8'h22); run_frame(8'hA5, cap); join
        bus_rd(2'd2, rd); chk("R6 overrun set", rd, 8'h07);
        bus_wr(2'd0, 8'h77);
        e0 = edges;
        repeat (40) @(negedge clk);
        chk("R7 locked no clock", 8'(edges - e0), 8'h00);
        bus_rd(2'd2, rd); chk("R7 byte pending", rd, 8'h06);
        bus_rd(2'd1, rd); chk("R6 old byte kept", rd, 8'h3C);
        fork bus_wr(2'd2, 8'h03); run_frame(8'h5E, cap); join
        chk("R7 resumes sdo", cap, 8'h77);
        bus_rd(2'd2, rd); chk("R7 overrun cleared", rd, 8'h03);
        bus_wr(2'd3, 8'h00);
        bus_rd(2'd1, rd); chk("R4 after resume", rd, 8'h5E);

        // R10 abort
        bus_wr(2'd0, 8'hC3);
        bus_wr(2'd3, 8'h03);
        repeat (5) @(negedge clk);
        bus_wr(2'd3, 8'h00);
        chk("R10 sck high", {7'd0, sck}, 8'h01);
        e0 = edges;
        repeat (20) @(negedge clk);
        chk("R10 stays idle", 8'(edges - e0), 8'h00);
        bus_rd(2'd2, rd); chk("R10 byte consumed", rd, 8'h01);

        // R9 receive only
        fork bus_wr(2'd3, 8'h02); run_frame(8'h96, cap); join
        chk("R9 sdo idle high", cap, 8'hFF);
        bus_wr(2'd3, 8'h00);
        bus_rd(2'd1, rd); chk("R9 rx byte", rd, 8'h96);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule